// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block tracks where each hardware thread stands in the front end of a multithreaded processor. For every thread it holds a status code, the current fetch address and its successor, four sticky stall flags, and the ID of the newest instruction-cache request it issued. It takes stall and release pulses from four later stages. It also takes redirect requests from the commit and decode stages, a level that says the reorder buffer is still flushing, and the handshakes of the instruction cache.

Only one rejected cache request can wait at a time, so it sits in a single retry slot shared by all threads. While that slot is full, the cache counts as blocked and no thread can issue a new request. Each cache response carries a thread index and a request ID. A response for a thread that is no longer waiting, or that carries an old ID, is thrown away and counted. Instruction decoding and branch prediction are handled elsewhere.

Top module: `fetch_thread_ctrl`

## Requirements
- R1: After reset the following hold. Every thread's state is Running. `thr_pc` is `RESET_PC` and `thr_npc` is `RESET_PC + INST_BYTES`. The retry slot is empty, `cache_blocked` is 0 and `drop_cnt` is 0. State codes are: Running 0, Idle 1, Squashing 2, Blocked 3, WaitResponse 4, WaitRetry 5, AccessComplete 6, TrapPending 7, QuiescePending 8.
- R2: Each thread has one sticky stall flag per source. Bit `t*4+s` of `blk_set` sets the flag and the same bit of `blk_clr` clears it. Source s is 0 decode, 1 rename, 2 execute, 3 commit. While any flag of a thread is set, the thread moves to Blocked unless it is in WaitResponse. Other threads are unaffected.
- R3: A commit squash has the highest priority. It puts the thread in Squashing and loads the pc with the commit target and the next pc with target+INST_BYTES. It wins over a decode squash in the same cycle.
- R4: While `rob_busy` is high and there is no commit squash, the thread stays in Squashing.
- R5: A decode squash puts a thread that is not in Squashing into Squashing and loads the decode target. A decode squash that arrives while the thread is already in Squashing leaves the pc unchanged.
- R6: A thread in Blocked or Squashing returns to Running in the first cycle with no squash, no reorder-buffer flush and no stall flag.
- R7: A request issues only when `req_go` names a Running thread and the cache is not blocked. Each issue increments that thread's request ID, which starts at 0. An accepted request moves the thread to WaitResponse. A rejected one moves it to WaitRetry and stores the thread and ID in the retry slot, which raises `cache_blocked`. While the cache is blocked, requests from any thread are ignored.
- R8: `retry_ok` with a full slot empties the slot and drops `cache_blocked`. If the owning thread is in WaitRetry, it moves to WaitResponse.
- R9: A commit squash or an accepted decode squash of the thread that owns the retry slot empties the slot and drops `cache_blocked`. A squash of another thread leaves the slot alone.
- R10: A response is accepted only when its thread is in WaitResponse, its ID equals that thread's newest ID, and no squash or reorder-buffer flush hits that thread in the same cycle. An accepted response moves the thread to Blocked if a stall flag is set, and to AccessComplete otherwise. Any other response is dropped and `drop_cnt` increments by one.
- R11: A fetch turn (`turn_valid` with `turn_tid`) moves a thread from AccessComplete to Running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_set | input | NTHR*4 | Stall pulses, bit t*4+s |
| blk_clr | input | NTHR*4 | Release pulses, bit t*4+s |
| cmt_squash | input | NTHR | Commit redirect per thread |
| cmt_target | input | NTHR*PCW | Commit redirect addresses |
| rob_busy | input | NTHR | Reorder buffer still flushing |
| dec_squash | input | NTHR | Decode redirect per thread |
| dec_target | input | NTHR*PCW | Decode redirect addresses |
| req_go | input | 1 | Fetch wants a cache line |
| req_tid | input | TW | Thread of the request |
| req_accept | input | 1 | Cache takes the request this cycle |
| retry_ok | input | 1 | Cache can take the parked request |
| rsp_valid | input | 1 | Cache response present |
| rsp_tid | input | TW | Thread of the response |
| rsp_id | input | IDW | Request ID of the response |
| turn_valid | input | 1 | Fetch turn present |
| turn_tid | input | TW | Thread taking the turn |
| thr_state | output | NTHR*4 | State code per thread |
| thr_pc | output | NTHR*PCW | Fetch address per thread |
| thr_npc | output | NTHR*PCW | Next fetch address per thread |
| cache_blocked | output | 1 | Retry slot occupied |
| retry_valid | output | 1 | Retry slot holds a request |
| retry_tid | output | TW | Thread owning the slot |
| retry_id | output | IDW | ID of the parked request |
| drop_cnt | output | CNTW | Count of discarded responses |

## Verification
Every register drives a port one cycle later. A wrong priority between the squash sources shows on `thr_state` and `thr_pc` right after the cycle in which they collide. A lost or stuck stall flag shows as a thread that leaves or fails to leave Blocked once the release pulse has been applied. A wrong request ID or stale-response check shows within a cycle as a wrong state code next to a change in `drop_cnt`. A retry slot that is not cleared shows as `cache_blocked` held high while another thread's request is ignored.

// File: rtl/fetch_thread_ctrl.sv
module fetch_thread_ctrl #(
  parameter int NTHR = 2,
  parameter int PCW = 32,
  parameter int IDW = 4,
  parameter int CNTW = 8,
  parameter int INST_BYTES = 4,
  parameter logic [PCW-1:0] RESET_PC = '0,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int NSRC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NTHR*NSRC-1:0] blk_set,
  input  logic [NTHR*NSRC-1:0] blk_clr,
  input  logic [NTHR-1:0]      cmt_squash,
  input  logic [NTHR*PCW-1:0]  cmt_target,
  input  logic [NTHR-1:0]      rob_busy,
  input  logic [NTHR-1:0]      dec_squash,
  input  logic [NTHR*PCW-1:0]  dec_target,
  input  logic                 req_go,
  input  logic [TW-1:0]        req_tid,
  input  logic                 req_accept,
  input  logic                 retry_ok,
  input  logic                 rsp_valid,
  input  logic [TW-1:0]        rsp_tid,
  input  logic [IDW-1:0]       rsp_id,
  input  logic                 turn_valid,
  input  logic [TW-1:0]        turn_tid,
  output logic [NTHR*4-1:0]    thr_state,
  output logic [NTHR*PCW-1:0]  thr_pc,
  output logic [NTHR*PCW-1:0]  thr_npc,
  output logic                 cache_blocked,
  output logic                 retry_valid,
  output logic [TW-1:0]        retry_tid,
  output logic [IDW-1:0]       retry_id,
  output logic [CNTW-1:0]      drop_cnt
);
  localparam logic [3:0] S_RUN   = 4'd0;
  localparam logic [3:0] S_SQ    = 4'd2;
  localparam logic [3:0] S_BLK   = 4'd3;
  localparam logic [3:0] S_WRSP  = 4'd4;
  localparam logic [3:0] S_WRTY  = 4'd5;
  localparam logic [3:0] S_ACC   = 4'd6;

  logic [NSRC-1:0] stall_q [NTHR];
  logic [3:0]      st_q    [NTHR];
  logic [PCW-1:0]  pc_q    [NTHR];
  logic [IDW-1:0]  oid_q   [NTHR];
  logic            slot_v;
  logic [TW-1:0]   slot_tid;
  logic [IDW-1:0]  slot_id;
  logic [CNTW-1:0] drop_q;
  logic [NTHR-1:0] issue_v, sq_v, drop_v;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    wire [NSRC-1:0] stall_n = (stall_q[t] | blk_set[t*NSRC +: NSRC]) & ~blk_clr[t*NSRC +: NSRC];
    wire stall_any = |stall_n;
    wire dec_ok    = dec_squash[t] && (st_q[t] != S_SQ);
    wire ctl       = cmt_squash[t] || rob_busy[t] || dec_ok ||
                     (stall_any && st_q[t] != S_WRSP) ||
                     st_q[t] == S_BLK || st_q[t] == S_SQ;
    wire mine_rsp  = rsp_valid && (rsp_tid == TW'(t));
    wire rsp_hit   = mine_rsp && !ctl && st_q[t] == S_WRSP && rsp_id == oid_q[t];
    wire retry_hit = retry_ok && slot_v && slot_tid == TW'(t) && st_q[t] == S_WRTY;
    wire turn_hit  = turn_valid && turn_tid == TW'(t) && st_q[t] == S_ACC;
    logic [3:0] st_n;

    assign issue_v[t] = req_go && req_tid == TW'(t) && !ctl && st_q[t] == S_RUN && !slot_v;
    assign sq_v[t]    = cmt_squash[t] || dec_ok;
    assign drop_v[t]  = mine_rsp && !rsp_hit;

    always_comb begin
      st_n = st_q[t];
      if (cmt_squash[t] || rob_busy[t] || dec_ok) st_n = S_SQ;
      else if (stall_any && st_q[t] != S_WRSP)    st_n = S_BLK;
      else if (st_q[t] == S_BLK || st_q[t] == S_SQ) st_n = S_RUN;
      else if (rsp_hit)    st_n = stall_any ? S_BLK : S_ACC;
      else if (turn_hit)   st_n = S_RUN;
      else if (issue_v[t]) st_n = req_accept ? S_WRSP : S_WRTY;
      else if (retry_hit)  st_n = S_WRSP;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[t]    <= S_RUN;
        stall_q[t] <= '0;
        pc_q[t]    <= RESET_PC;
        oid_q[t]   <= '0;
      end else begin
        st_q[t]    <= st_n;
        stall_q[t] <= stall_n;
        if (cmt_squash[t])   pc_q[t] <= cmt_target[t*PCW +: PCW];
        else if (dec_ok)     pc_q[t] <= dec_target[t*PCW +: PCW];
        if (issue_v[t])      oid_q[t] <= oid_q[t] + IDW'(1);
      end
    end

    assign thr_state[t*4 +: 4]   = st_q[t];
    assign thr_pc[t*PCW +: PCW]  = pc_q[t];
    assign thr_npc[t*PCW +: PCW] = pc_q[t] + PCW'(INST_BYTES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v   <= 1'b0;
      slot_tid <= '0;
      slot_id  <= '0;
      drop_q   <= '0;
    end else begin
      if (|issue_v && !req_accept) begin
        slot_v   <= 1'b1;
        slot_tid <= req_tid;
        slot_id  <= oid_q[req_tid] + IDW'(1);
      end else if (retry_ok) begin
        slot_v   <= 1'b0;
      end else if (slot_v && sq_v[slot_tid]) begin
        slot_v   <= 1'b0;
      end
      if (|drop_v) drop_q <= drop_q + CNTW'(1);
    end
  end

  assign cache_blocked = slot_v;
  assign retry_valid   = slot_v;
  assign retry_tid     = slot_tid;
  assign retry_id      = slot_id;
  assign drop_cnt      = drop_q;
endmodule

module fetch_thread_ctrl_chk #(
  parameter int NTHR = 2,
  parameter int PCW = 32,
  parameter int CNTW = 8,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NTHR-1:0]     cmt_squash,
  input logic [NTHR*PCW-1:0] cmt_target,
  input logic [NTHR-1:0]     rob_busy,
  input logic [NTHR*4-1:0]   thr_state,
  input logic [NTHR*PCW-1:0] thr_pc,
  input logic                retry_valid,
  input logic [TW-1:0]       retry_tid,
  input logic [CNTW-1:0]     drop_cnt
);
  logic [NTHR-1:0] in_retry;

  for (genvar t = 0; t < NTHR; t++) begin : g_chk
    assign in_retry[t] = thr_state[t*4 +: 4] == 4'd5;

    a_r3_commit_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_squash[t] |=> (thr_state[t*4 +: 4] == 4'd2 &&
                         thr_pc[t*PCW +: PCW] == $past(cmt_target[t*PCW +: PCW])));

    a_r4_rob_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rob_busy[t] |=> thr_state[t*4 +: 4] == 4'd2);

    a_r7_retry_owner: assert property (@(posedge clk) disable iff (!rst_n)
      in_retry[t] |-> (retry_valid && retry_tid == TW'(t)));
  end

  a_r7_single_waiter: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_retry) <= 1);

  a_r10_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt == $past(drop_cnt)) || (drop_cnt == $past(drop_cnt) + CNTW'(1)));
endmodule

bind fetch_thread_ctrl fetch_thread_ctrl_chk #(.NTHR(NTHR), .PCW(PCW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmt_squash(cmt_squash), .cmt_target(cmt_target),
  .rob_busy(rob_busy), .thr_state(thr_state), .thr_pc(thr_pc),
  .retry_valid(retry_valid), .retry_tid(retry_tid), .drop_cnt(drop_cnt));

// File: tb/tb_fetch_thread_ctrl.sv
module tb_fetch_thread_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NTHR = 2;
  localparam int PCW = 32;
  localparam int IDW = 4;
  localparam int CNTW = 8;
  localparam int NV = 26;
  // {op, expected thread-0 state}
  localparam logic [7:0] VEC [NV] = '{
    8'h00, 8'h13, 8'h03, 8'h20, 8'h32, 8'h42, 8'h00, 8'h64, 8'h14, 8'h93,
    8'h20, 8'h64, 8'hA4, 8'h96, 8'h06, 8'hB0, 8'h75, 8'h84, 8'h96, 8'hB0,
    8'h75, 8'h32, 8'h50, 8'h52, 8'hC2, 8'h00};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NTHR*4-1:0]   blk_set, blk_clr;
  logic [NTHR-1:0]     cmt_squash, rob_busy, dec_squash;
  logic [NTHR*PCW-1:0] cmt_target, dec_target;
  logic req_go, req_accept, retry_ok, rsp_valid, turn_valid;
  logic [0:0] req_tid, rsp_tid, turn_tid;
  logic [IDW-1:0] rsp_id;
  logic [NTHR*4-1:0]   thr_state;
  logic [NTHR*PCW-1:0] thr_pc, thr_npc;
  logic cache_blocked, retry_valid;
  logic [0:0] retry_tid;
  logic [IDW-1:0] retry_id;
  logic [CNTW-1:0] drop_cnt;

  int nchk = 0, nfail = 0;
  int eid [NTHR] = '{0, 0};
  bit done = 0;

  fetch_thread_ctrl #(.NTHR(NTHR), .PCW(PCW), .IDW(IDW), .CNTW(CNTW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic clear_in();
    blk_set = '0; blk_clr = '0; cmt_squash = '0; rob_busy = '0; dec_squash = '0;
    cmt_target = '0; dec_target = '0; req_go = 0; req_accept = 0; retry_ok = 0;
    rsp_valid = 0; turn_valid = 0; req_tid = '0; rsp_tid = '0; turn_tid = '0; rsp_id = '0;
  endtask

  task automatic check(input int act, input int exp, input string tag);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      1, 2, 14, 15: return "R2";
      3, 12:        return "R3";
      4:            return "R4";
      5:            return "R5";
      6, 7, 13:     return "R7";
      8:            return "R8";
      9, 10:        return "R10";
      11:           return "R11";
      default:      return "R6";
    endcase
  endfunction

  function automatic int st(input int t);
    return int'(thr_state[t*4 +: 4]);
  endfunction

  task automatic do_op(input int op, input int t);
    case (op)
      1:  blk_set[t*4] = 1'b1;
      2:  blk_clr[t*4] = 1'b1;
      3:  begin cmt_squash[t] = 1'b1; cmt_target[t*PCW +: PCW] = 32'h100; end
      4:  rob_busy[t] = 1'b1;
      5:  begin dec_squash[t] = 1'b1; dec_target[t*PCW +: PCW] = 32'h200; end
      6:  begin req_go = 1; req_tid = 1'(t); req_accept = 1; eid[t]++; end
      7:  begin req_go = 1; req_tid = 1'(t); req_accept = 0; eid[t]++; end
      8:  retry_ok = 1;
      9:  begin rsp_valid = 1; rsp_tid = 1'(t); rsp_id = IDW'(eid[t]); end
      10: begin rsp_valid = 1; rsp_tid = 1'(t); rsp_id = IDW'(eid[t] - 1); end
      11: begin turn_valid = 1; turn_tid = 1'(t); end
      12: begin cmt_squash[t] = 1'b1; cmt_target[t*PCW +: PCW] = 32'h100;
                dec_squash[t] = 1'b1; dec_target[t*PCW +: PCW] = 32'h200; end
      13: begin req_go = 1; req_tid = 1'(t); req_accept = 1; end
      14: blk_set[t*4+1] = 1'b1;
      15: blk_clr[t*4+1] = 1'b1;
      default: ;
    endcase
    @(posedge clk); #1;
    clear_in();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    clear_in();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check(st(0), 0, "R1 state0");
    check(st(1), 0, "R1 state1");
    check(int'(thr_pc[0 +: PCW]), 0, "R1 pc");
    check(int'(thr_npc[0 +: PCW]), 4, "R1 npc");
    check(int'(cache_blocked), 0, "R1 cache_blocked");
    check(int'(drop_cnt), 0, "R1 drop_cnt");

    for (int i = 0; i < NV; i++) begin
      do_op(int'(VEC[i][7:4]), 0);
      check(st(0), int'(VEC[i][3:0]), $sformatf("%s vec%0d", tag_of(int'(VEC[i][7:4])), i));
    end

    check(int'(thr_pc[0 +: PCW]), 32'h100, "R3 commit beats decode pc");
    check(int'(thr_npc[0 +: PCW]), 32'h104, "R3 npc");
    check(int'(drop_cnt), 1, "R10 stale drop");

    do_op(3, 0);
    do_op(5, 0);
    check(int'(thr_pc[0 +: PCW]), 32'h100, "R5 decode ignored while squashing");
    check(st(0), 0, "R6 back to running");

    do_op(7, 0);
    check(st(0), 5, "R7 reject state");
    check(int'(retry_valid), 1, "R7 slot valid");
    check(int'(retry_tid), 0, "R7 slot tid");
    check(int'(retry_id), eid[0], "R7 slot id");
    check(int'(cache_blocked), 1, "R7 cache blocked");
    do_op(13, 1);
    check(st(1), 0, "R7 request ignored while blocked");
    do_op(3, 1);
    check(int'(retry_valid), 1, "R9 other thread squash keeps slot");
    do_op(8, 0);
    check(int'(cache_blocked), 0, "R8 retry releases");
    check(int'(retry_valid), 0, "R8 slot freed");
    check(st(0), 4, "R8 owner waits response");
    check(st(1), 0, "R6 thread1 running");

    do_op(6, 1);
    check(st(1), 4, "R7 thread1 accepted");
    do_op(9, 1);
    check(st(1), 6, "R10 thread1 response");
    check(st(0), 4, "R10 thread0 still waiting");

    do_op(3, 0);
    do_op(9, 0);
    check(int'(drop_cnt), 2, "R10 response after squash dropped");
    check(st(0), 0, "R6 thread0 running");

    do_op(7, 0);
    do_op(5, 0);
    check(int'(retry_valid), 0, "R9 owner squash frees slot");
    check(int'(cache_blocked), 0, "R9 cache released");
    check(int'(thr_pc[0 +: PCW]), 32'h200, "R5 decode target");

    do_op(14, 1);
    check(st(1), 3, "R2 rename stall blocks thread1");
    check(st(0), 0, "R2 thread0 unaffected");
    do_op(0, 1);
    check(st(1), 3, "R2 stall sticky");
    do_op(15, 1);
    check(st(1), 0, "R2 release returns running");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule